// File: doc/BRIEF.md
# Multi-Register Load/Store Sequencer

This block turns a single block-transfer command into a stream of one-word memory requests. A command names one of four operations: load with incrementing address, store with incrementing address, stack push, or stack pop. It also carries a base register index, the current base value, an 8-bit list of low registers and one extra selector bit. For a push the extra bit adds the link register, and for a pop it adds the program counter. The block issues one request per cycle in ascending register order, so the lowest-numbered register always sits at the lowest address. It then reports the new base value, together with a one-cycle done pulse.

Push and pop always work on the stack pointer and treat the stack as full descending. A push therefore starts its writes below the current stack pointer and leaves the pointer at the lowest written word. A pop reads upward from the current pointer. Write-back of the base is unconditional. A pop that restores the program counter also raises a branch request that carries the word loaded for it. Register-file access and memory are outside the block. Load data is returned combinationally on `rd_data` for the address being requested.

The controller has three states. IDLE waits for `start`. IDLE→XFER is taken on a legal command. IDLE→FINISH is taken on an illegal one. XFER issues one request per cycle and moves XFER→FINISH on the last selected register. FINISH lasts one cycle, presents done, write-back, error and branch results, and returns FINISH→IDLE.

Top module: `regxfer_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `req_valid`, `done`, `wb_en`, `err` and `branch_valid` are all 0.
- R2: Requests come one per cycle in ascending register index, at consecutive word addresses 4 apart. Request k (k = 0, 1, …) is presented in the (k+1)-th cycle after the clock edge that samples `start`. `req_write` is 1 for store and push and 0 for load and pop. The `op` encoding is: 0 = load-increment, 1 = store-increment, 2 = push, 3 = pop.
- R3: For load-increment and store-increment, the first address is `base_val`, the transfers are the set bits of `reg_list` (register index = bit position), and `wb_idx` = `base_idx`. The write-back value is `base_val` + 4·n, where n is the number of listed registers. `extra` has no effect on these forms.
- R4: For push, the base is register 13 whatever `base_idx` holds. n counts the list bits plus `extra`, the first address is `base_val` − 4·n, and the link register (index 14) is transferred last when `extra` = 1. The written-back stack pointer equals the first address.
- R5: For pop, the base is register 13, the first address is `base_val`, the program counter (index 15) is loaded last when `extra` = 1, and the written-back value is `base_val` + 4·n.
- R6: An empty effective list, or an increment form whose `reg_list` contains bit `base_idx`, produces no request. One cycle after the start edge the block pulses `done` with `err` = 1 and `wb_en` = 0.
- R7: A legal command pulses `done` and `wb_en` for exactly one cycle, in the cycle after its last request, with `err` = 0.
- R8: A pop with `extra` = 1 asserts `branch_valid` in the done cycle, with `branch_target` equal to the word returned on `rd_data` for the program-counter request. Every other command leaves `branch_valid` at 0.
- R9: A `start` pulse that arrives while `busy` is 1 is ignored and leaves the running sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, sampled when idle |
| op | input | 2 | Operation code (see R2) |
| base_idx | input | 3 | Base register for the increment forms |
| base_val | input | 32 | Current base or stack-pointer value |
| reg_list | input | 8 | Low-register selection |
| extra | input | 1 | Adds link register (push) or program counter (pop) |
| rd_data | input | 32 | Load data for the current request address |
| busy | output | 1 | Command in progress |
| req_valid | output | 1 | Memory request this cycle |
| req_addr | output | 32 | Word address of the request |
| req_reg | output | 4 | Register index transferred |
| req_write | output | 1 | 1 = store to memory, 0 = load |
| done | output | 1 | Completion pulse |
| wb_en | output | 1 | Base write-back is valid |
| wb_idx | output | 4 | Register receiving the write-back |
| wb_base | output | 32 | Updated base value |
| err | output | 1 | Illegal command reported with done |
| branch_valid | output | 1 | Program counter was loaded by pop |
| branch_target | output | 32 | Loaded program-counter value |

## Verification
A pop that includes the program counter makes completion, base write-back and the branch request fall in the same FINISH cycle. The bench provokes this with directed and random pops that have `extra` set, using a memory filled with a known pattern. In that one cycle it judges `done`, `wb_en`, `wb_base` and `branch_target` against values it computed itself. Illegal commands put the error report in the same cycle as `done`, and the bench checks that this cycle also carries no write-back.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;

    typedef enum logic [1:0] {
        OP_LDI  = 2'd0,
        OP_STI  = 2'd1,
        OP_PUSH = 2'd2,
        OP_POP  = 2'd3
    } xop_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_FINISH = 2'd2
    } xstate_t;

    localparam int REG_IDX_W = 4;
    localparam logic [REG_IDX_W-1:0] SP_IDX = 4'd13;
    localparam logic [REG_IDX_W-1:0] LR_IDX = 4'd14;
    localparam logic [REG_IDX_W-1:0] PC_IDX = 4'd15;

endpackage

// File: rtl/regxfer_plan.sv
// Decodes a command into the effective transfer mask, start address,
// write-back value and legality.
module regxfer_plan
    import regxfer_pkg::*;
#(
    parameter int LIST_W = 8,
    parameter int ADDR_W = 32,
    localparam int IDX_W = $clog2(LIST_W),
    localparam int CNT_W = $clog2(LIST_W + 2)
) (
    input  xop_t                  op,
    input  logic [IDX_W-1:0]      base_idx,
    input  logic [ADDR_W-1:0]     base_val,
    input  logic [LIST_W-1:0]     reg_list,
    input  logic                  extra,
    output logic [LIST_W:0]       eff_mask,
    output logic [ADDR_W-1:0]     first_addr,
    output logic [ADDR_W-1:0]     wb_val,
    output logic [REG_IDX_W-1:0]  wb_idx,
    output logic                  bad
);

    logic              stack_op;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] span;

    assign stack_op = (op == OP_PUSH) || (op == OP_POP);
    // The extra bit only joins the list for the stack forms.
    assign eff_mask = {extra & stack_op, reg_list};

    always_comb begin
        cnt = '0;
        for (int i = 0; i <= LIST_W; i++) begin
            cnt = cnt + CNT_W'(eff_mask[i]);
        end
    end

    assign span = ADDR_W'({cnt, 2'b00});

    always_comb begin
        bad = (eff_mask == '0);
        if (!stack_op && reg_list[base_idx]) begin
            bad = 1'b1;
        end
    end

    always_comb begin
        unique case (op)
            OP_PUSH: begin
                first_addr = base_val - span;
                wb_val     = base_val - span;
                wb_idx     = SP_IDX;
            end
            OP_POP: begin
                first_addr = base_val;
                wb_val     = base_val + span;
                wb_idx     = SP_IDX;
            end
            default: begin
                first_addr = base_val;
                wb_val     = base_val + span;
                wb_idx     = REG_IDX_W'(base_idx);
            end
        endcase
    end

endmodule

// File: rtl/regxfer_pick.sv
// Lowest-set-bit finder built as a ripple chain of "something below" flags.
module regxfer_pick #(
    parameter int W = 9,
    localparam int SEL_W = $clog2(W)
) (
    input  logic [W-1:0]     mask,
    output logic [W-1:0]     onehot,
    output logic [SEL_W-1:0] sel,
    output logic             last
);

    logic [W:0] below;

    assign below[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_chain
        assign below[i+1] = below[i] | mask[i];
        assign onehot[i]  = mask[i] & ~below[i];
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) begin
                sel = sel | SEL_W'(i);
            end
        end
    end

    // Only one bit left means this pick is the final transfer.
    assign last = (mask != '0) && (mask == onehot);

endmodule

// File: rtl/regxfer_seq.sv
module regxfer_seq
    import regxfer_pkg::*;
#(
    parameter int LIST_W = 8,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LIST_W),
    localparam int MASK_W = LIST_W + 1,
    localparam int SEL_W  = $clog2(MASK_W)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           op,
    input  logic [IDX_W-1:0]     base_idx,
    input  logic [ADDR_W-1:0]    base_val,
    input  logic [LIST_W-1:0]    reg_list,
    input  logic                 extra,
    input  logic [DATA_W-1:0]    rd_data,
    output logic                 busy,
    output logic                 req_valid,
    output logic [ADDR_W-1:0]    req_addr,
    output logic [REG_IDX_W-1:0] req_reg,
    output logic                 req_write,
    output logic                 done,
    output logic                 wb_en,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [ADDR_W-1:0]    wb_base,
    output logic                 err,
    output logic                 branch_valid,
    output logic [DATA_W-1:0]    branch_target
);

    xstate_t state_q, state_d;

    xop_t                  op_in, op_q;
    logic [MASK_W-1:0]     plan_mask, mask_q;
    logic [ADDR_W-1:0]     plan_first, plan_wb, addr_q, wbv_q;
    logic [REG_IDX_W-1:0]  plan_wbidx, wbidx_q;
    logic                  plan_bad, err_q;
    logic [DATA_W-1:0]     pc_q;
    logic                  pc_hit_q;

    logic [MASK_W-1:0]     pick_oh;
    logic [SEL_W-1:0]      pick_sel;
    logic                  pick_last;

    assign op_in = xop_t'(op);

    regxfer_plan #(
        .LIST_W (LIST_W),
        .ADDR_W (ADDR_W)
    ) u_plan (
        .op         (op_in),
        .base_idx   (base_idx),
        .base_val   (base_val),
        .reg_list   (reg_list),
        .extra      (extra),
        .eff_mask   (plan_mask),
        .first_addr (plan_first),
        .wb_val     (plan_wb),
        .wb_idx     (plan_wbidx),
        .bad        (plan_bad)
    );

    regxfer_pick #(
        .W (MASK_W)
    ) u_pick (
        .mask   (mask_q),
        .onehot (pick_oh),
        .sel    (pick_sel),
        .last   (pick_last)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = plan_bad ? ST_FINISH : ST_XFER;
                end
            end
            ST_XFER: begin
                if (pick_last) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Command and progress registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_LDI;
            mask_q   <= '0;
            addr_q   <= '0;
            wbv_q    <= '0;
            wbidx_q  <= '0;
            err_q    <= 1'b0;
            pc_q     <= '0;
            pc_hit_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q     <= op_in;
                        mask_q   <= plan_bad ? '0 : plan_mask;
                        addr_q   <= plan_first;
                        wbv_q    <= plan_wb;
                        wbidx_q  <= plan_wbidx;
                        err_q    <= plan_bad;
                        pc_hit_q <= 1'b0;
                    end
                end
                ST_XFER: begin
                    mask_q <= mask_q & ~pick_oh;
                    addr_q <= addr_q + ADDR_W'(4);
                    if (op_q == OP_POP && pick_oh[LIST_W]) begin
                        pc_q     <= rd_data;
                        pc_hit_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Output logic.
    always_comb begin
        busy          = 1'b0;
        req_valid     = 1'b0;
        done          = 1'b0;
        wb_en         = 1'b0;
        err           = 1'b0;
        branch_valid  = 1'b0;
        req_addr      = addr_q;
        wb_idx        = wbidx_q;
        wb_base       = wbv_q;
        branch_target = pc_q;
        req_write     = (op_q == OP_STI) || (op_q == OP_PUSH);
        if (pick_sel == SEL_W'(LIST_W)) begin
            req_reg = (op_q == OP_PUSH) ? LR_IDX : PC_IDX;
        end else begin
            req_reg = REG_IDX_W'(pick_sel);
        end
        unique case (state_q)
            ST_IDLE: ;
            ST_XFER: begin
                busy      = 1'b1;
                req_valid = 1'b1;
            end
            ST_FINISH: begin
                busy         = 1'b1;
                done         = 1'b1;
                wb_en        = !err_q;
                err          = err_q;
                branch_valid = pc_hit_q;
            end
            default: ;
        endcase
    end

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid)) |-> (req_addr == $past(req_addr) + ADDR_W'(4)));

    // R2
    reg_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid)) |-> (req_reg > $past(req_reg)));

    // R2
    dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid)) |-> $stable(req_write));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    err_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !wb_en));

    // R8
    branch_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |-> (done && !err));

endmodule

// File: tb/tb_regxfer_seq.sv
module tb_regxfer_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [2:0]  base_idx = '0;
    logic [31:0] base_val = '0;
    logic [7:0]  reg_list = '0;
    logic        extra = 1'b0;
    logic [31:0] rd_data;
    logic        busy, req_valid, req_write, done, wb_en, err, branch_valid;
    logic [31:0] req_addr, wb_base, branch_target;
    logic [3:0]  req_reg, wb_idx;

    logic [31:0] mem [256];
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rd_data = mem[req_addr[9:2]];

    regxfer_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .base_idx(base_idx),
        .base_val(base_val), .reg_list(reg_list), .extra(extra), .rd_data(rd_data),
        .busy(busy), .req_valid(req_valid), .req_addr(req_addr), .req_reg(req_reg),
        .req_write(req_write), .done(done), .wb_en(wb_en), .wb_idx(wb_idx),
        .wb_base(wb_base), .err(err), .branch_valid(branch_valid),
        .branch_target(branch_target)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int count9(logic [8:0] m);
        int c = 0;
        for (int i = 0; i < 9; i++) c += int'(m[i]);
        return c;
    endfunction

    // Runs one command; when poke is set a stray start is applied mid-run (R9).
    task automatic run(logic [1:0] o, logic [2:0] bi, logic [31:0] bv,
                       logic [7:0] lst, logic ex, bit poke);
        logic [8:0]  m;
        int          n;
        bit          bad;
        bit          stk;
        logic [31:0] first, wbv, exp_pc, a;
        logic [3:0]  widx;
        int          k;
        string       rq;
        stk = (o == 2'd2) || (o == 2'd3);
        m   = {ex & stk, lst};
        n   = count9(m);
        bad = (m == 9'd0) || (!stk && lst[bi]);
        first = (o == 2'd2) ? bv - 32'(4 * n) : bv;
        wbv   = (o == 2'd2) ? first : bv + 32'(4 * n);
        widx  = stk ? 4'd13 : {1'b0, bi};
        rq    = (o == 2'd2) ? "R4" : (o == 2'd3) ? "R5" : "R3";
        exp_pc = mem[8'((bv + 32'(4 * n) - 32'd4) >> 2)];

        @(negedge clk);
        op = o; base_idx = bi; base_val = bv; reg_list = lst; extra = ex; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!bad) begin
            a = first;
            k = 0;
            for (int i = 0; i < 9; i++) begin
                if (m[i]) begin
                    check("R2", "req_valid", 32'(req_valid), 32'd1);
                    check(rq, "req_addr", req_addr, a);
                    check(rq, "req_reg", 32'(req_reg),
                          (i < 8) ? 32'(i) : ((o == 2'd2) ? 32'd14 : 32'd15));
                    check("R2", "req_write", 32'(req_write),
                          32'((o == 2'd1) || (o == 2'd2)));
                    check("R7", "done early", 32'(done), 32'd0);
                    if (poke && k == 0 && n >= 2) begin
                        // R9: stray command while busy
                        op = 2'd3; base_val = 32'h300; reg_list = 8'hFF; extra = 1'b1;
                        start = 1'b1;
                    end
                    a = a + 32'd4;
                    k++;
                    @(negedge clk);
                    start = 1'b0;
                end
            end
        end
        check(bad ? "R6" : "R7", "done", 32'(done), 32'd1);
        check(bad ? "R6" : "R7", "err", 32'(err), 32'(bad));
        check(bad ? "R6" : "R7", "wb_en", 32'(wb_en), 32'(!bad));
        check("R6", "no request", 32'(req_valid), 32'd0);
        if (!bad) begin
            check(rq, "wb_base", wb_base, wbv);
            check(rq, "wb_idx", 32'(wb_idx), 32'(widx));
        end
        check("R8", "branch_valid", 32'(branch_valid), 32'(!bad && o == 2'd3 && ex));
        if (!bad && o == 2'd3 && ex) check("R8", "branch_target", branch_target, exp_pc);
        @(negedge clk);
        check(poke ? "R9" : "R7", "idle after done", 32'({busy, done, req_valid}), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h01010101) ^ 32'hC3A5_0000;
        unused_seed = $urandom(32'h5EED_0042);
        #(CLK_PERIOD * 2 + 3);
        // R1: reset state
        check("R1", "reset outputs",
              32'({busy, req_valid, done, wb_en, err, branch_valid}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "idle after reset", 32'({busy, req_valid, done}), 32'd0);

        run(2'd0, 3'd1, 32'h240, 8'b1010_0101, 1'b1, 0); // R3 extra ignored
        run(2'd1, 3'd7, 32'h280, 8'b0111_1111, 1'b0, 0); // R3
        run(2'd2, 3'd0, 32'h300, 8'b1000_0011, 1'b1, 0); // R4 with LR
        run(2'd2, 3'd5, 32'h300, 8'h00, 1'b1, 0);        // R4 LR only
        run(2'd3, 3'd2, 32'h2C0, 8'b0001_0110, 1'b1, 0); // R5/R8 with PC
        run(2'd3, 3'd2, 32'h2C0, 8'b0001_0110, 1'b0, 0); // R5 no PC
        run(2'd0, 3'd3, 32'h240, 8'h00, 1'b1, 0);        // R6 empty
        run(2'd1, 3'd4, 32'h240, 8'b0001_0001, 1'b0, 0); // R6 base listed
        run(2'd3, 3'd0, 32'h200, 8'h00, 1'b0, 0);        // R6 empty pop
        run(2'd0, 3'd0, 32'h260, 8'b0110_0010, 1'b0, 1); // R9 stray start
        run(2'd2, 3'd0, 32'h3C0, 8'hFF, 1'b1, 0);        // R4 full list

        for (int t = 0; t < 60; t++) begin
            logic [1:0] ro;
            logic [2:0] rb;
            logic [7:0] rl;
            ro = 2'($urandom % 4);
            rb = 3'($urandom % 8);
            rl = 8'($urandom);
            if (($urandom % 4) != 0 && ro < 2'd2) rl[rb] = 1'b0;
            run(ro, rb, 32'h240 + 32'(4 * ($urandom % 40)), rl,
                1'($urandom % 2), ($urandom % 5) == 0);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule